// File: doc/BRIEF.md
# Packed Dual-Halfword Signed Add/Subtract Unit

This block treats each of two 32-bit operands as a pair of signed 16-bit halfwords. It computes one of four lane operations, picked by a 3-bit operation code. The first is an add in both lanes and the last is a subtract in both lanes. The two middle codes are exchange forms: each lane of the first operand is combined with the opposite halfword of the second operand, one lane adding and the other subtracting. The two 16-bit lane results are packed into a 32-bit word with plain wrap-around and no saturation. A 4-bit greater-or-equal vector carries a pair of identical bits per lane. A pair is set when that lane's exact, unwrapped result is zero or positive.

Each issued operation carries a 4-bit condition code, which is checked against the N, Z, C and V flags supplied with it. The operation takes effect only when the condition holds. When it does, the result and flag registers load and a write-enable strobe for each one is raised. When the condition fails or the operation code is reserved, both registers keep their old contents. A reserved operation code also raises an illegal-operation indication.

Issue has no back-pressure. An operation is taken on every cycle in which `in_valid` is high. Its outcome appears on the registered outputs one cycle later, marked by `out_valid`, and the consumer must take it in that cycle.

Top module: `dhw_addsub`

## Requirements
- R1: While `rst_n` is low and after it rises, before any issue: `out_valid`, `out_rd_we`, `out_ge_we` and `out_illegal` are 0, `out_result` is 0 and `out_ge` is 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid`, `out_rd_we`, `out_ge_we` and `out_illegal` are all low.
- R3: Operation code 0 gives low = a[15:0] + b[15:0] and high = a[31:16] + b[31:16].
- R4: Operation code 1 gives low = a[15:0] - b[31:16] and high = a[31:16] + b[15:0].
- R5: Operation code 2 gives low = a[15:0] + b[31:16] and high = a[31:16] - b[15:0].
- R6: Operation code 3 gives low = a[15:0] - b[15:0] and high = a[31:16] - b[31:16].
- R7: All halfwords are sign-extended. `out_result[15:0]` holds bits 15:0 of the low lane result and `out_result[31:16]` holds bits 15:0 of the high lane result. Results wrap without saturation.
- R8: `out_ge[1:0]` are both 1 when the exact low-lane result is >= 0 and both 0 otherwise. `out_ge[3:2]` follow the same rule for the high lane.
- R9: `in_flags` is {N,Z,C,V} from bit 3 down to bit 0. The condition codes hold as follows: 0 when Z, 1 when !Z, 2 when C, 3 when !C, 4 when N, 5 when !N, 6 when V, 7 when !V, 8 when C&!Z, 9 when !C|Z, 10 when N==V, 11 when N!=V, 12 when !Z&(N==V), 13 when Z|(N!=V), 14 always. Code 15 never executes.
- R10: A legal operation whose condition fails leaves `out_rd_we`, `out_ge_we` and `out_illegal` low with `out_valid` high, and `out_result` and `out_ge` keep their previous values.
- R11: Operation codes 4 to 7 raise `out_illegal` with `out_valid` and keep both write enables low, whatever the condition. `out_result` and `out_ge` are held.
- R12: A legal operation whose condition holds raises both `out_rd_we` and `out_ge_we` together with `out_valid`, and loads `out_result` and `out_ge` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe, accepted every cycle |
| in_op | input | 3 | Operation code (0..3 legal, 4..7 reserved) |
| in_cond | input | 4 | Condition code |
| in_flags | input | 4 | {N,Z,C,V} flags used for the condition |
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| out_valid | output | 1 | Outcome of the previous cycle's issue |
| out_result | output | 32 | Held packed result |
| out_ge | output | 4 | Held greater-or-equal flag pairs |
| out_rd_we | output | 1 | Result written this cycle |
| out_ge_we | output | 1 | Flags written this cycle |
| out_illegal | output | 1 | Reserved operation code was issued |

## Verification
The bench builds the block with its default lane width of 16 bits. This places the halfword extremes 0x7FFF and 0x8000 within reach of directed operands, so results can cross the 16-bit range in both directions. That exposes the difference between the wrapped packed value and the exact 17-bit sign that drives the flag pairs. All sixteen condition codes are swept against all sixteen flag combinations, and every reserved operation code is issued with each kind of condition.

// File: rtl/dhw_pkg.sv
package dhw_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ASX = 3'd1;
  localparam logic [2:0] OP_SAX = 3'd2;
  localparam logic [2:0] OP_SUB = 3'd3;
endpackage

// File: rtl/dhw_cond_eval.sv
module dhw_cond_eval (
  input  logic [3:0]     cond,
  input  dhw_pkg::nzcv_t flags,
  output logic           pass
);
  logic base;

  // Codes come in pairs; bit 0 inverts the test of the pair.
  always_comb begin
    unique case (cond[3:1])
      3'd0: base = flags.z;
      3'd1: base = flags.c;
      3'd2: base = flags.n;
      3'd3: base = flags.v;
      3'd4: base = flags.c & ~flags.z;
      3'd5: base = flags.n == flags.v;
      3'd6: base = ~flags.z & (flags.n == flags.v);
      default: base = 1'b1;
    endcase
  end

  assign pass = cond[0] ? ~base : base;
endmodule

// File: rtl/dhw_lane.sv
module dhw_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         nonneg
);
  logic [W:0] xe;
  logic [W:0] ye;
  logic [W:0] sum;

  assign xe     = {x[W-1], x};
  assign ye     = {y[W-1], y};
  assign sum    = sub ? (xe - ye) : (xe + ye);
  assign res    = sum[W-1:0];
  assign nonneg = ~sum[W];
endmodule

// File: rtl/dhw_addsub.sv
module dhw_addsub #(
  parameter int LANE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_op,
  input  logic [3:0]          in_cond,
  input  logic [3:0]          in_flags,
  input  logic [2*LANE_W-1:0] in_a,
  input  logic [2*LANE_W-1:0] in_b,
  output logic                out_valid,
  output logic [2*LANE_W-1:0] out_result,
  output logic [3:0]          out_ge,
  output logic                out_rd_we,
  output logic                out_ge_we,
  output logic                out_illegal
);
  import dhw_pkg::*;

  localparam int LANES = 2;
  localparam int DW    = LANES * LANE_W;

  logic [LANE_W-1:0] a_h [LANES];
  logic [LANE_W-1:0] b_h [LANES];
  logic [LANE_W-1:0] lane_res [LANES];
  logic [LANES-1:0]  lane_nn;
  logic              xchg;
  logic              legal;
  logic              pass;
  logic              commit;
  logic [DW-1:0]     res_next;
  logic [3:0]        ge_next;

  assign legal = ~in_op[2];
  assign xchg  = in_op[0] ^ in_op[1];

  dhw_cond_eval u_cond (
    .cond  (in_cond),
    .flags (nzcv_t'(in_flags)),
    .pass  (pass)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic sub_g;
    assign a_h[g] = in_a[g*LANE_W +: LANE_W];
    assign b_h[g] = in_b[g*LANE_W +: LANE_W];
    // Low lane subtracts on codes 1 and 3, high lane on codes 2 and 3.
    if (g == 0) begin : g_lo
      assign sub_g = in_op[0];
    end else begin : g_hi
      assign sub_g = in_op[1];
    end
    dhw_lane #(.W(LANE_W)) u_lane (
      .x      (a_h[g]),
      .y      (xchg ? b_h[LANES-1-g] : b_h[g]),
      .sub    (sub_g),
      .res    (lane_res[g]),
      .nonneg (lane_nn[g])
    );
    assign res_next[g*LANE_W +: LANE_W] = lane_res[g];
  end

  assign ge_next = {{2{lane_nn[1]}}, {2{lane_nn[0]}}};
  assign commit  = in_valid & legal & pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_rd_we   <= 1'b0;
      out_ge_we   <= 1'b0;
      out_result  <= '0;
      out_ge      <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & ~legal;
      out_rd_we   <= commit;
      out_ge_we   <= commit;
      if (commit) begin
        out_result <= res_next;
        out_ge     <= ge_next;
      end
    end
  end
endmodule

// File: rtl/dhw_addsub_chk.sv
module dhw_addsub_chk #(
  parameter int LANE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2:0]          in_op,
  input logic [3:0]          in_cond,
  input logic [2*LANE_W-1:0] out_result,
  input logic [3:0]          out_ge,
  input logic                out_valid,
  input logic                out_rd_we,
  input logic                out_ge_we,
  input logic                out_illegal
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_rd_we && !out_ge_we && !out_illegal);
  // R11
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op[2] |=> out_illegal && !out_rd_we && !out_ge_we);
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rd_we |-> $stable(out_result));
  // R10
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ge_we |-> $stable(out_ge));
  // R8
  ge_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ge[0] == out_ge[1] && out_ge[2] == out_ge[3]);
  // R9
  always_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_op[2] && in_cond == 4'hE |=> out_rd_we && out_ge_we);
endmodule

bind dhw_addsub dhw_addsub_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/dhw_addsub_tb.sv
module dhw_addsub_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          due;
    bit          valid;
    bit          we;
    bit          ill;
    logic [31:0] res;
    logic [3:0]  ge;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [2:0]  in_op = 0;
  logic [3:0]  in_cond = 0;
  logic [3:0]  in_flags = 0;
  logic [31:0] in_a = 0;
  logic [31:0] in_b = 0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [3:0]  out_ge;
  logic        out_rd_we;
  logic        out_ge_we;
  logic        out_illegal;

  int          n_checks = 0;
  int          n_fail = 0;
  int          cyc = 0;
  exp_t        q[$];
  logic [31:0] m_res = 0;
  logic [3:0]  m_ge = 0;

  dhw_addsub u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cc, v;
    {n, z, cc, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cc;
      4'd3:  return !cc;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cc && !z;
      4'd9:  return !cc || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                       input logic [3:0] c, input logic [3:0] f, input string tag);
    exp_t e;
    int al, ah, bl, bh, lo, hi;
    @(negedge clk);
    in_valid = 1; in_a = a; in_b = b; in_op = op; in_cond = c; in_flags = f;
    al = int'($signed(a[15:0])); ah = int'($signed(a[31:16]));
    bl = int'($signed(b[15:0])); bh = int'($signed(b[31:16]));
    case (op)
      3'd0: begin lo = al + bl; hi = ah + bh; end
      3'd1: begin lo = al - bh; hi = ah + bl; end
      3'd2: begin lo = al + bh; hi = ah - bl; end
      default: begin lo = al - bl; hi = ah - bh; end
    endcase
    e.due = cyc + 1; e.valid = 1; e.tag = tag;
    e.ill = op[2];
    e.we = !op[2] && cond_ok(c, f);
    if (e.we) begin
      m_res = {hi[15:0], lo[15:0]};
      m_ge = {(hi >= 0) ? 2'b11 : 2'b00, (lo >= 0) ? 2'b11 : 2'b00};
    end
    e.res = m_res; e.ge = m_ge;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 0; in_op = 3'd5; in_cond = 4'hE; in_a = 32'hFFFF_FFFF;
    e.due = cyc + 1; e.valid = 0; e.we = 0; e.ill = 0;
    e.res = m_res; e.ge = m_ge; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops the item due after the latest rising edge
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "valid", 32'(out_valid), 32'(e.valid));
      check(e.tag, "rd_we", 32'(out_rd_we), 32'(e.we));
      check(e.tag, "ge_we", 32'(out_ge_we), 32'(e.we));
      check(e.tag, "illegal", 32'(out_illegal), 32'(e.ill));
      check(e.tag, "result", out_result, e.res);
      check(e.tag, "ge", 32'(out_ge), 32'(e.ge));
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "valid", 32'(out_valid), 0);
    check("R1", "result", out_result, 0);
    check("R1", "ge", 32'(out_ge), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "we", 32'({out_rd_we, out_ge_we, out_illegal}), 0);
    check("R1", "result_after", out_result, 0);

    // R3 parallel add, including low-lane overflow past 0x7FFF (R7, R8)
    drive(32'h1234_7FFF, 32'h0001_0001, 3'd0, 4'hE, 4'h0, "R3");
    drive(32'h8000_FFFF, 32'hFFFF_FFFF, 3'd0, 4'hE, 4'h0, "R3");
    drive(32'h0000_0000, 32'h0000_0000, 3'd0, 4'hE, 4'h0, "R8");
    // R4 exchange: low subtracts b_hi, high adds b_lo
    drive(32'h0010_0020, 32'h0003_0005, 3'd1, 4'hE, 4'h0, "R4");
    drive(32'h7FFF_8000, 32'h0001_0001, 3'd1, 4'hE, 4'h0, "R4");
    // R5 exchange: low adds b_hi, high subtracts b_lo
    drive(32'h0010_0020, 32'h0003_0005, 3'd2, 4'hE, 4'h0, "R5");
    drive(32'h8000_7FFF, 32'h0001_0001, 3'd2, 4'hE, 4'h0, "R5");
    // R6 parallel subtract with wrap (R7)
    drive(32'h8000_0005, 32'h0001_0007, 3'd3, 4'hE, 4'h0, "R6");
    drive(32'h7FFF_8000, 32'hFFFF_7FFF, 3'd3, 4'hE, 4'h0, "R7");
    drive(32'h1111_2222, 32'h1111_2222, 3'd3, 4'hE, 4'h0, "R8");
    idle("R2");
    // R9 full sweep of conditions and flags; values vary so holds are visible
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        drive(32'(c * 32'h0101_0013 + f), 32'(f * 32'h0700_0031), 3'(f % 4), 4'(c), 4'(f), "R9");
      end
    end
    // R10 condition fail holds previous result
    drive(32'h4444_5555, 32'h1111_1111, 3'd0, 4'hE, 4'h0, "R12");
    drive(32'h0000_0001, 32'h7FFF_7FFF, 3'd3, 4'h0, 4'h0, "R10");
    drive(32'h0000_0001, 32'h7FFF_7FFF, 3'd3, 4'hF, 4'hF, "R10");
    // R11 reserved codes with passing, failing and always conditions
    for (int op = 4; op < 8; op++) begin
      drive(32'hA5A5_5A5A, 32'h0F0F_F0F0, 3'(op), 4'hE, 4'h0, "R11");
      drive(32'hA5A5_5A5A, 32'h0F0F_F0F0, 3'(op), 4'h0, 4'h4, "R11");
      drive(32'hA5A5_5A5A, 32'h0F0F_F0F0, 3'(op), 4'h1, 4'h4, "R11");
    end
    idle("R2");
    drive(32'h0002_0003, 32'h0001_0001, 3'd1, 4'h4, 4'h8, "R12");
    idle("R2");
    idle("R2");
    while (q.size() > 0) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule